// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block is the transmit half of the MAC side of a 4-bit media-independent interface. A frame source hands over the bytes of one frame at a time through a valid/ready handshake, with a start marker on the first byte and an end marker on the last. The serializer inserts the preamble and the start-of-frame delimiter itself. It cuts each byte into two nibbles and presents one nibble per transmit clock on the data pins, together with the transmit-enable and transmit-error pins. All of these are registered in the PHY-supplied transmit clock domain, so the PHY samples them on the rising edge. The frame check sequence is expected to be part of the byte stream already.

The block can abandon a frame that is already on the wire. An abort request, or a source that fails to deliver a byte on time, makes the serializer raise the error pin for the rest of the frame, so that the PHY corrupts the frame instead of the frame being silently cut short. The rest of the source's bytes are then taken and thrown away until the end marker arrives. After every frame an inter-frame gap of idle nibble periods is enforced before the next start byte can begin a frame.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `txd` is 0, `tx_en` is 0, `tx_er` is 0 and `in_ready` is 0 unless a beat without a start marker is offered.
- R2: Each frame opens with 15 nibbles of 0x5 and then one nibble of 0xD. These are the first 16 cycles in which `tx_en` is high.
- R3: Each byte goes out as two nibbles in consecutive cycles, bits [3:0] first and bits [7:4] second, directly after the delimiter. `tx_en` stays high without a break, so a frame of N bytes lasts exactly 16+2N cycles.
- R4: Whenever `tx_en` is low, `txd` is 0 and `tx_er` is 0.
- R5: During a frame, `in_ready` is high at most every other cycle. At most one byte is taken per two nibble periods.
- R6: When `abort_req` is high at a clock edge during the preamble or the data, the nibble clocked out at that edge carries `tx_er`=1 and `txd`=0. `tx_er` then stays high for as long as `tx_en` stays high.
- R7: An underrun aborts the frame. An underrun is a data phase in which `in_ready` is high but `in_valid` is low. The nibble clocked out at that edge already carries `tx_er`=1.
- R8: After an abort, bytes are still accepted every other cycle and discarded. The nibble clocked out at the edge that takes the end-marked byte is the last one with `tx_en` high.
- R9: Between two frames, `tx_en` is low for at least 24 consecutive cycles. A start-marked beat offered earlier is held off by `in_ready`=0.
- R10: A beat offered while idle without the start marker is taken and dropped, and no frame starts.
- R11: A frame that is neither aborted nor underrun keeps `tx_er` at 0 for its whole length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock from the PHY, one nibble per period |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Frame byte offered by the source |
| in_valid | input | 1 | Source offers a byte |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last of a frame |
| in_ready | output | 1 | Byte is taken at this clock edge when valid |
| abort_req | input | 1 | Request to corrupt the frame in progress |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | Frame in progress |
| tx_er | output | 1 | Frame is to be corrupted by the PHY |

## Verification
A corrupted phase bit or a wrongly held high nibble appears at once at the pins, because the two halves of a byte come out in adjacent cycles. The same fault also breaks the every-other-cycle rhythm of `in_ready`, one cycle after the first faulty nibble. A fault in the preamble counter changes where the 0xD nibble lands, which makes the frame length differ from 16+2N when `tx_en` falls. A gap counter that ends too soon, or an error flag that clears too early, can only be seen at the next frame start or in the next cycle that `tx_en` stays high. The bench therefore measures the idle run before each frame and checks every nibble captured after the first error.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_ABRT,
    ST_GAP
  } tx_state_t;

  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;
  localparam logic [NIB_W-1:0] IDLE_NIB = 4'h0;

endpackage

// File: rtl/mii_tx_span_counter.sv
module mii_tx_span_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              abort_req,
  input  logic              pre_done,
  input  logic              gap_done,
  output logic              in_ready,
  output logic              pre_run,
  output logic              gap_run,
  output logic [NIB_W-1:0]  nib_d,
  output logic              nib_en,
  output logic              nib_er
);
  tx_state_t        state_q, state_n;
  logic             phase_q, phase_n;
  logic [NIB_W-1:0] hi_q, hi_n;
  logic             last_q, last_n;

  always_comb begin
    state_n  = state_q;
    phase_n  = phase_q;
    hi_n     = hi_q;
    last_n   = last_q;
    in_ready = 1'b0;
    pre_run  = 1'b0;
    gap_run  = 1'b0;
    nib_d    = IDLE_NIB;
    nib_en   = 1'b0;
    nib_er   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready = in_valid && !in_sof;
        last_n   = 1'b0;
        phase_n  = 1'b0;
        if (in_valid && in_sof) begin
          state_n = ST_PRE;
        end
      end
      ST_PRE: begin
        nib_en  = 1'b1;
        pre_run = 1'b1;
        if (abort_req) begin
          nib_er  = 1'b1;
          state_n = ST_ABRT;
          phase_n = 1'b0;
        end else begin
          nib_d = pre_done ? SFD_NIB : PRE_NIB;
          if (pre_done) begin
            state_n = ST_DATA;
            phase_n = 1'b0;
          end
        end
      end
      ST_DATA: begin
        nib_en = 1'b1;
        if (!phase_q) begin
          in_ready = !abort_req;
          phase_n  = 1'b1;
          if (abort_req || !in_valid) begin
            nib_er  = 1'b1;
            state_n = ST_ABRT;
          end else begin
            nib_d  = in_data[NIB_W-1:0];
            hi_n   = in_data[BYTE_W-1:NIB_W];
            last_n = in_eof;
          end
        end else begin
          phase_n = 1'b0;
          if (abort_req) begin
            nib_er  = 1'b1;
            state_n = last_q ? ST_GAP : ST_ABRT;
          end else begin
            nib_d = hi_q;
            if (last_q) begin
              state_n = ST_GAP;
            end
          end
        end
      end
      ST_ABRT: begin
        nib_en  = 1'b1;
        nib_er  = 1'b1;
        phase_n = !phase_q;
        if (!phase_q) begin
          in_ready = 1'b1;
          if (in_valid && in_eof) begin
            state_n = ST_GAP;
            phase_n = 1'b0;
          end
        end
      end
      ST_GAP: begin
        gap_run = 1'b1;
        if (gap_done) begin
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      hi_q    <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      hi_q    <= hi_n;
      last_q  <= last_n;
    end
  end
endmodule

// File: rtl/mii_tx_out_stage.sv
module mii_tx_out_stage
  import mii_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_d,
  input  logic             nib_en,
  input  logic             nib_er,
  output logic [NIB_W-1:0] txd,
  output logic             tx_en,
  output logic             tx_er
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txd   <= IDLE_NIB;
      tx_en <= 1'b0;
      tx_er <= 1'b0;
    end else begin
      txd   <= nib_en ? nib_d : IDLE_NIB;
      tx_en <= nib_en;
      tx_er <= nib_en && nib_er;
    end
  end
endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer #(
  parameter int PRE_NIBBLES = 16,
  parameter int GAP_NIBBLES = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       in_ready,
  input  logic       abort_req,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  import mii_tx_pkg::*;

  logic             pre_run, pre_done;
  logic             gap_run, gap_done;
  logic [NIB_W-1:0] nib_d;
  logic             nib_en, nib_er;

  mii_tx_span_counter #(.LIMIT(PRE_NIBBLES)) i_pre_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (pre_run),
    .done (pre_done)
  );

  mii_tx_span_counter #(.LIMIT(GAP_NIBBLES)) i_gap_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (gap_run),
    .done (gap_done)
  );

  mii_tx_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .abort_req (abort_req),
    .pre_done  (pre_done),
    .gap_done  (gap_done),
    .in_ready  (in_ready),
    .pre_run   (pre_run),
    .gap_run   (gap_run),
    .nib_d     (nib_d),
    .nib_en    (nib_en),
    .nib_er    (nib_er)
  );

  mii_tx_out_stage i_out (
    .clk    (clk),
    .rst    (rst),
    .nib_d  (nib_d),
    .nib_en (nib_en),
    .nib_er (nib_er),
    .txd    (txd),
    .tx_en  (tx_en),
    .tx_er  (tx_er)
  );
endmodule

// File: rtl/mii_tx_checker.sv
module mii_tx_checker #(
  parameter int GAP_NIBBLES = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic [3:0] txd,
  input logic       tx_en,
  input logic       tx_er
);
  localparam int IW = $clog2(GAP_NIBBLES + 1);
  localparam logic [IW-1:0] IMAX = IW'(GAP_NIBBLES);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= IMAX;
    end else if (tx_en) begin
      idle_q <= '0;
    end else if (idle_q != IMAX) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (txd == 4'h0 && !tx_er));

  assert_pre_first_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && !tx_er) |-> (txd == 4'h5));

  assert_ready_cadence_R5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && tx_en) |=> !in_ready);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_er) |=> (tx_er || !tx_en));

  assert_gap_len_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (idle_q >= IMAX));
endmodule

bind mii_tx_serializer mii_tx_checker #(.GAP_NIBBLES(GAP_NIBBLES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_en    (tx_en),
  .tx_er    (tx_er)
);

// File: tb/test_mii_tx_serializer.sv
module test_mii_tx_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, abort_req = 1'b0;
  logic       in_ready, tx_en, tx_er;
  logic [3:0] txd;

  int errors = 0, checks = 0;

  // {byte, expected first nibble, expected second nibble}
  localparam logic [15:0] VEC [8] = '{
    {8'hA7, 4'h7, 4'hA}, {8'h3C, 4'hC, 4'h3}, {8'h00, 4'h0, 4'h0}, {8'hFF, 4'hF, 4'hF},
    {8'hD5, 4'h5, 4'hD}, {8'h55, 4'h5, 4'h5}, {8'h12, 4'h2, 4'h1}, {8'hE9, 4'h9, 4'hE}
  };

  always #2.5 clk = ~clk;

  mii_tx_serializer i_mii_tx_serializer (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_ready(in_ready), .abort_req(abort_req),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  // capture monitor
  logic [3:0] cap_d [256];
  logic       cap_er [256];
  int  len = 0, frames_done = 0, idle_run = 0, last_gap = 0;
  int  idle_bad = 0, rdy_bad = 0;
  logic prev_en = 1'b0, prev_rdy = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_en) begin
        if (!prev_en) begin
          last_gap = idle_run;
          len = 0;
        end
        if (len < 256) begin
          cap_d[len]  = txd;
          cap_er[len] = tx_er;
        end
        len++;
        idle_run = 0;
        if (in_ready && prev_rdy) rdy_bad++;
      end else begin
        if (prev_en) frames_done++;
        if (txd != 4'h0 || tx_er) idle_bad++;
        idle_run++;
      end
      prev_en  = tx_en;
      prev_rdy = in_ready && tx_en;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input int hold_after, input int hold_cycles);
    for (int i = 0; i < n; i++) begin
      if (i == hold_after) begin
        in_valid = 1'b0;
        repeat (hold_cycles) @(posedge clk);
        #1;
      end
      in_data  = VEC[i % 8][15:8];
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames_done < target) @(negedge clk);
  endtask

  // er must stay high from index from_idx up to len-1
  task automatic chk_sticky(input string req, input int from_idx);
    int bad = 0;
    for (int i = from_idx; i < len; i++) if (!cap_er[i] || cap_d[i] != 4'h0) bad++;
    chk(bad == 0, req, "error nibbles after abort", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pre_bad;
    int er_cnt;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(txd == 4'h0 && !tx_en && !tx_er, "R1", "outputs in reset", {txd, tx_en, tx_er}, 0);
    chk(!in_ready, "R1", "ready in reset", in_ready, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && !in_ready, "R1", "first cycle after reset", {tx_en, in_ready}, 0);

    // Frame A: full table walk, 8 bytes
    send_frame(8, -1, 0);
    wait_frames(1);
    pre_bad = 0;
    for (int i = 0; i < 15; i++) if (cap_d[i] != 4'h5) pre_bad++;
    chk(pre_bad == 0, "R2", "preamble nibbles", pre_bad, 0);
    chk(cap_d[15] == 4'hD, "R2", "delimiter nibble", cap_d[15], 4'hD);
    for (int i = 0; i < 8; i++) begin
      chk({cap_d[16 + 2*i], cap_d[17 + 2*i]} == {VEC[i][7:4], VEC[i][3:0]}, "R3",
          $sformatf("nibble order byte %0d", i),
          {cap_d[16 + 2*i], cap_d[17 + 2*i]}, {VEC[i][7:4], VEC[i][3:0]});
    end
    chk(len == 32, "R3", "frame length 8 bytes", len, 32);
    er_cnt = 0;
    for (int i = 0; i < len; i++) if (cap_er[i]) er_cnt++;
    chk(er_cnt == 0, "R11", "no error in clean frame", er_cnt, 0);

    // Frame B back to back: gap hold-off
    send_frame(2, -1, 0);
    wait_frames(2);
    chk(last_gap >= 24, "R9", "idle gap before frame B", last_gap, 24);
    chk(len == 20, "R3", "frame length 2 bytes", len, 20);

    // Underrun after byte 2
    send_frame(6, 3, 5);
    wait_frames(3);
    chk(cap_er[21] == 1'b0 && cap_d[21] == VEC[2][3:0], "R7", "nibble before underrun",
        {cap_er[21], cap_d[21]}, {1'b0, VEC[2][3:0]});
    chk(cap_er[22] == 1'b1, "R7", "error at underrun nibble", cap_er[22], 1);
    chk_sticky("R7", 22);

    // Abort request during data (seen at second nibble of byte 3)
    fork
      send_frame(8, -1, 0);
      begin
        wait (tx_en);
        repeat (22) @(posedge clk);
        #1 abort_req = 1'b1;
        @(posedge clk);
        #1 abort_req = 1'b0;
      end
    join
    wait_frames(4);
    chk(cap_er[22] == 1'b0 && cap_d[22] == 4'hF, "R6", "nibble before abort",
        {cap_er[22], cap_d[22]}, {1'b0, 4'hF});
    chk(cap_er[23] == 1'b1, "R6", "error at abort nibble", cap_er[23], 1);
    chk_sticky("R6", 23);
    chk(len == 31, "R8", "aborted frame ends at end byte", len, 31);

    // Abort during preamble
    fork
      send_frame(4, -1, 0);
      begin
        wait (tx_en);
        repeat (3) @(posedge clk);
        #1 abort_req = 1'b1;
        @(posedge clk);
        #1 abort_req = 1'b0;
      end
    join
    wait_frames(5);
    chk(cap_er[3] == 1'b0 && cap_er[4] == 1'b1, "R6", "preamble abort point",
        {cap_er[3], cap_er[4]}, 2'b01);
    chk(len == 12, "R8", "preamble-aborted frame length", len, 12);

    // Stray beat while idle without start marker
    repeat (30) @(posedge clk);
    #1;
    in_data = 8'h77;
    in_valid = 1'b1;
    in_sof = 1'b0;
    in_eof = 1'b1;
    @(negedge clk);
    chk(in_ready && !tx_en, "R10", "stray beat taken", {in_ready, tx_en}, 2'b10);
    @(posedge clk);
    #1 in_valid = 1'b0;
    in_eof = 1'b0;
    repeat (20) @(negedge clk);
    chk(!tx_en && frames_done == 5, "R10", "no frame from stray beat", frames_done, 5);

    chk(idle_bad == 0, "R4", "idle pins quiet", idle_bad, 0);
    chk(rdy_bad == 0, "R5", "ready cadence", rdy_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule